// File: doc/BRIEF.md
# Vector Shape Schedule Configurator

This block turns a compact shape command into the four 32-bit shape-descriptor words and the 7-bit total iteration count that a vector loop sequencer needs. The command has three 5-bit dimension fields (x, y, z) and a 4-bit mode. The modes cover matrix multiply, FFT butterflies, DCT inner and outer butterflies, DCT cosine-table generation and three half-swap reorderings. Along with the descriptors, the block produces an updated copy of a 64-bit shared state word. The remap-control fields of that word are wiped unless its persist flag is set.

A one-cycle start pulse captures the command while the block is idle. Several iteration counts depend on the number of butterfly stages. That number is the run of consecutive 1 bits at the bottom of x, and it is found by a small sequencer that handles one stage per cycle. When the sequencer finishes, all results are registered together and done pulses. The results then stay unchanged until the next command completes.

Top module: `vshape_config`

## Requirements
- R1: While reset is held and after it is released, all descriptors, the count and the state output are zero, and done and busy are low.
- R2: A start pulse that arrives while busy is low captures x, y, z, mode and the state input. Let n be the number of consecutive 1 bits in x counted upward from bit 0 (0 to 5). Busy stays high for n+1 cycles, and done is high for exactly one cycle, n+1 clock edges after the edge that sampled start. A start pulse that arrives while busy is high is ignored and produces no extra done.
- R3: All outputs hold their values from one done pulse until the next.
- R4: In the state output, bits 63:32 are always zero and bits 16:2 copy the input. When input bit 1 (persist) is 0, bits 31:17, bit 1 and bit 0 are cleared. Otherwise those bits copy the input.
- R5: Descriptor field layout, with every field not named here left at zero: X in bits 31:26, Y in 25:20, Z in 19:14, PERM in 13:11, INV in 10:8, SCHED in 3:2, KIND in 1:0. The 6-bit fields hold zero-extended values. Mode 0 (matrix) gives a count of (x+1)(y+1)(z+1) mod 128. Descriptor 0 holds X=x, Y=y, Z=z and SCHED=3, and descriptor 3 equals descriptor 0. Descriptor 1 is descriptor 0 with PERM=1 and SCHED=1. Descriptor 2 is descriptor 0 with PERM=1.
- R6: Mode 1 (FFT) gives a count of (x+1)·n mod 128. Descriptor 0 holds X=x, Z=z and KIND=1. Descriptor 1 is descriptor 0 with SCHED=1, descriptor 2 is descriptor 0 with SCHED=2, and descriptor 3 is zero.
- R7: Modes 4 and 12 (DCT inner, forward and inverse) give a count of (x+1)·n mod 128. The template holds X=x, Z=z and Y=3. Mode 4 adds KIND=1, PERM=1 and INV=1. Mode 12 adds KIND=3 and PERM=3. Descriptor 1 is the template, descriptor 0 is the template with SCHED=1, descriptor 2 is the template with SCHED=2 and Z=0, and descriptor 3 is zero.
- R8: Modes 3 and 11 (DCT outer) start from acc=0, size=1 and it=(x+1)/2. Each of the n stages adds (it−1)·size to acc, doubles size and halves it, and the count is acc mod 128. The template holds X=x, Z=z and Y=2. Mode 3 adds KIND=1 and PERM=4. Mode 11 adds KIND=3, PERM=3 and INV=5. Descriptor 0 is the template, descriptor 1 is the template with SCHED=1, descriptor 2 is the template with Z=0, and descriptor 3 is zero.
- R9: Modes 5 and 13 (cosine table) start from acc=0 and it=(x+1)/2. Each of the n stages adds it to acc and halves it, and the count is acc mod 128. The template holds X=x, Z=z, Y=4 and KIND=1, and mode 5 also sets INV=1. Descriptor 0 is the template, descriptor 1 is the template with SCHED=2, descriptor 2 is the template with SCHED=3, and descriptor 3 is zero.
- R10: Modes 6, 14 and 15 (half-swap) give a count of x+1. Only descriptor 0 is non-zero. It holds X=x, Z=z and Y=5, with KIND=1 for mode 15 and KIND=3 otherwise. Mode 14 also sets PERM=1.
- R11: Modes 2, 7, 8, 9 and 10 give all-zero descriptors and a count of zero. The state rule of R4 still applies, and done still pulses after n+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Command strobe, one cycle |
| x_i | input | 5 | X dimension field |
| y_i | input | 5 | Y dimension field |
| z_i | input | 5 | Z dimension field |
| mode_i | input | 4 | Schedule mode code |
| state_i | input | 64 | Shared state word before the command |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Results valid pulse |
| desc0_o | output | 32 | Shape descriptor 0 |
| desc1_o | output | 32 | Shape descriptor 1 |
| desc2_o | output | 32 | Shape descriptor 2 |
| desc3_o | output | 32 | Shape descriptor 3 |
| count_o | output | 7 | Total iteration count |
| state_o | output | 64 | Shared state word after the command |

## Verification
Every result of the block arrives together, n+1 edges after the edge that samples start. The value of n is known from x alone, so the bench computes the expected arrival cycle from x when it issues the command and compares it with the cycle in which the monitor sees done. The monitor samples only on falling edges and compares everything in that same cycle. The bench then looks again one cycle later to confirm that done has dropped and the outputs have held. Commands with no stages (n=0) and with the full five stages cover the short and long ends of the timing.

// File: rtl/vshape_pkg.sv
`timescale 1ns/100ps
package vshape_pkg;
  localparam int DIM_W   = 5;
  localparam int MODE_W  = 4;
  localparam int WORD_W  = 32;
  localparam int CNT_W   = 7;
  localparam int ST_W    = 64;
  localparam int NDESC   = 4;
  localparam int STG_W   = $clog2(DIM_W + 1);
  localparam int ITER_W  = DIM_W + 1;

  typedef struct packed {
    logic [5:0] xd;
    logic [5:0] yd;
    logic [5:0] zd;
    logic [2:0] perm;
    logic [2:0] inv;
    logic [3:0] rsv;
    logic [1:0] sched;
    logic [1:0] kind;
  } desc_t;

  typedef enum logic [MODE_W-1:0] {
    M_MATRIX    = 4'd0,
    M_FFT       = 4'd1,
    M_OUTER     = 4'd3,
    M_INNER     = 4'd4,
    M_COS       = 4'd5,
    M_HALF      = 4'd6,
    M_OUTER_INV = 4'd11,
    M_INNER_INV = 4'd12,
    M_COS_INV   = 4'd13,
    M_HALF_INV  = 4'd14,
    M_HALF_FFT  = 4'd15
  } mode_e;

  // volume of the three dimensions, wrapped to the count width
  function automatic logic [CNT_W-1:0] vol_count(input logic [DIM_W-1:0] x,
                                                 input logic [DIM_W-1:0] y,
                                                 input logic [DIM_W-1:0] z);
    logic [CNT_W-1:0] a, b, c;
    a = CNT_W'(x) + CNT_W'(1);
    b = CNT_W'(y) + CNT_W'(1);
    c = CNT_W'(z) + CNT_W'(1);
    return a * b * c;
  endfunction

  // length times stage count, wrapped
  function automatic logic [CNT_W-1:0] nlogn_count(input logic [DIM_W-1:0] x,
                                                   input logic [STG_W-1:0] n);
    return (CNT_W'(x) + CNT_W'(1)) * CNT_W'(n);
  endfunction

  // bit idx of v, zero once idx runs past the field
  function automatic logic stage_bit(input logic [DIM_W-1:0] v,
                                     input logic [STG_W-1:0] idx);
    logic r;
    r = 1'b0;
    for (int i = 0; i < DIM_W; i++)
      if (idx == STG_W'(i)) r = v[i];
    return r;
  endfunction
endpackage

// File: rtl/vshape_stage_seq.sv
`timescale 1ns/100ps
module vshape_stage_seq import vshape_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DIM_W-1:0]  x_in,
  output logic              busy,
  output logic              step,
  output logic              finish,
  output logic [DIM_W-1:0]  x_q,
  output logic [STG_W-1:0]  stg_q,
  output logic [CNT_W-1:0]  outer_sum,
  output logic [CNT_W-1:0]  cos_sum
);
  logic [ITER_W-1:0] iter_q;
  logic [ITER_W-1:0] size_q;
  logic [CNT_W-1:0]  outer_add;

  assign step      = busy && stage_bit(x_q, stg_q);
  assign finish    = busy && !step;
  assign outer_add = CNT_W'(iter_q - ITER_W'(1)) * CNT_W'(size_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      x_q       <= '0;
      stg_q     <= '0;
      iter_q    <= '0;
      size_q    <= '0;
      outer_sum <= '0;
      cos_sum   <= '0;
    end else if (accept) begin
      busy      <= 1'b1;
      x_q       <= x_in;
      stg_q     <= '0;
      iter_q    <= (ITER_W'(x_in) + ITER_W'(1)) >> 1;
      size_q    <= ITER_W'(1);
      outer_sum <= '0;
      cos_sum   <= '0;
    end else if (busy) begin
      if (step) begin
        outer_sum <= outer_sum + outer_add;
        cos_sum   <= cos_sum + CNT_W'(iter_q);
        iter_q    <= iter_q >> 1;
        size_q    <= size_q << 1;
        stg_q     <= stg_q + STG_W'(1);
      end else begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vshape_desc_gen.sv
`timescale 1ns/100ps
module vshape_desc_gen import vshape_pkg::*; (
  input  logic [DIM_W-1:0]  x,
  input  logic [DIM_W-1:0]  y,
  input  logic [DIM_W-1:0]  z,
  input  logic [MODE_W-1:0] mode,
  output logic [NDESC-1:0][WORD_W-1:0] desc
);
  desc_t t;
  desc_t d [NDESC];

  always_comb begin
    t = '0;
    t.xd = {1'b0, x};
    t.zd = {1'b0, z};
    for (int i = 0; i < NDESC; i++) d[i] = '0;
    case (mode_e'(mode))
      M_MATRIX: begin
        t.yd = {1'b0, y};
        t.sched = 2'd3;
        d[0] = t;
        d[3] = t;
        d[1] = t; d[1].perm = 3'd1; d[1].sched = 2'd1;
        d[2] = t; d[2].perm = 3'd1;
      end
      M_FFT: begin
        t.kind = 2'd1;
        d[0] = t;
        d[1] = t; d[1].sched = 2'd1;
        d[2] = t; d[2].sched = 2'd2;
      end
      M_INNER, M_INNER_INV: begin
        t.yd = 6'd3;
        if (mode_e'(mode) == M_INNER_INV) begin
          t.kind = 2'd3; t.perm = 3'd3;
        end else begin
          t.kind = 2'd1; t.perm = 3'd1; t.inv = 3'd1;
        end
        d[1] = t;
        d[0] = t; d[0].sched = 2'd1;
        d[2] = t; d[2].sched = 2'd2; d[2].zd = '0;
      end
      M_OUTER, M_OUTER_INV: begin
        t.yd = 6'd2;
        if (mode_e'(mode) == M_OUTER_INV) begin
          t.kind = 2'd3; t.perm = 3'd3; t.inv = 3'd5;
        end else begin
          t.kind = 2'd1; t.perm = 3'd4;
        end
        d[0] = t;
        d[1] = t; d[1].sched = 2'd1;
        d[2] = t; d[2].zd = '0;
      end
      M_COS, M_COS_INV: begin
        t.yd = 6'd4;
        t.kind = 2'd1;
        if (mode_e'(mode) == M_COS) t.inv = 3'd1;
        d[0] = t;
        d[1] = t; d[1].sched = 2'd2;
        d[2] = t; d[2].sched = 2'd3;
      end
      M_HALF, M_HALF_INV, M_HALF_FFT: begin
        t.yd = 6'd5;
        t.kind = (mode_e'(mode) == M_HALF_FFT) ? 2'd1 : 2'd3;
        if (mode_e'(mode) == M_HALF_INV) t.perm = 3'd1;
        d[0] = t;
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < NDESC; g++) begin : g_pack
    assign desc[g] = d[g];
  end
endmodule

// File: rtl/vshape_state_upd.sv
`timescale 1ns/100ps
module vshape_state_upd import vshape_pkg::*; (
  input  logic [ST_W-1:0] st_in,
  output logic [ST_W-1:0] st_out
);
  localparam int HALF      = ST_W / 2;
  localparam int REMAP_HI  = HALF - 1;
  localparam int REMAP_LO  = HALF - 15;
  localparam int PERSIST   = 1;
  localparam int VFIRST    = 0;

  logic keep;
  assign keep = st_in[PERSIST];

  always_comb begin
    st_out = st_in;
    st_out[ST_W-1:HALF] = '0;
    if (!keep) begin
      st_out[REMAP_HI:REMAP_LO] = '0;
      st_out[PERSIST] = 1'b0;
      st_out[VFIRST]  = 1'b0;
    end
  end
endmodule

// File: rtl/vshape_config.sv
`timescale 1ns/100ps
module vshape_config import vshape_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [4:0]        x_i,
  input  logic [4:0]        y_i,
  input  logic [4:0]        z_i,
  input  logic [3:0]        mode_i,
  input  logic [63:0]       state_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [31:0]       desc0_o,
  output logic [31:0]       desc1_o,
  output logic [31:0]       desc2_o,
  output logic [31:0]       desc3_o,
  output logic [6:0]        count_o,
  output logic [63:0]       state_o
);
  // named internal events for the checker
  logic                accept;
  logic                stage_step;
  logic                seq_finish;
  logic [STG_W-1:0]    stage_cnt;
  logic [DIM_W-1:0]    x_q;
  logic [DIM_W-1:0]    y_q, z_q;
  logic [MODE_W-1:0]   mode_q;
  logic [ST_W-1:0]     state_q;
  logic [CNT_W-1:0]    outer_sum, cos_sum, cnt_next;
  logic [ST_W-1:0]     st_next;
  logic [NDESC-1:0][WORD_W-1:0] desc_next, desc_q;
  logic                done_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [ST_W-1:0]     st_q;

  assign accept = start_i && !busy_o;

  vshape_stage_seq u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .x_in(x_i),
    .busy(busy_o), .step(stage_step), .finish(seq_finish),
    .x_q(x_q), .stg_q(stage_cnt), .outer_sum(outer_sum), .cos_sum(cos_sum)
  );

  vshape_desc_gen u_desc (
    .x(x_q), .y(y_q), .z(z_q), .mode(mode_q), .desc(desc_next)
  );

  vshape_state_upd u_st (.st_in(state_q), .st_out(st_next));

  always_comb begin
    case (mode_e'(mode_q))
      M_MATRIX:                          cnt_next = vol_count(x_q, y_q, z_q);
      M_FFT, M_INNER, M_INNER_INV:       cnt_next = nlogn_count(x_q, stage_cnt);
      M_OUTER, M_OUTER_INV:              cnt_next = outer_sum;
      M_COS, M_COS_INV:                  cnt_next = cos_sum;
      M_HALF, M_HALF_INV, M_HALF_FFT:    cnt_next = CNT_W'(x_q) + CNT_W'(1);
      default:                           cnt_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_q     <= '0;
      z_q     <= '0;
      mode_q  <= '0;
      state_q <= '0;
      done_q  <= 1'b0;
      desc_q  <= '0;
      cnt_q   <= '0;
      st_q    <= '0;
    end else begin
      if (accept) begin
        y_q     <= y_i;
        z_q     <= z_i;
        mode_q  <= mode_i;
        state_q <= state_i;
      end
      done_q <= seq_finish;
      if (seq_finish) begin
        desc_q <= desc_next;
        cnt_q  <= cnt_next;
        st_q   <= st_next;
      end
    end
  end

  assign done_o  = done_q;
  assign desc0_o = desc_q[0];
  assign desc1_o = desc_q[1];
  assign desc2_o = desc_q[2];
  assign desc3_o = desc_q[3];
  assign count_o = cnt_q;
  assign state_o = st_q;
endmodule

// File: rtl/vshape_config_chk.sv
`timescale 1ns/100ps
module vshape_config_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [31:0] desc0_o,
  input logic [31:0] desc1_o,
  input logic [31:0] desc2_o,
  input logic [31:0] desc3_o,
  input logic [6:0]  count_o,
  input logic [63:0] state_o,
  input logic [3:0]  mode_q,
  input logic [63:0] state_q,
  input logic [2:0]  stage_cnt
);
  logic [3:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) lat_cnt <= '0;
    else        lat_cnt <= busy_o ? lat_cnt + 4'd1 : 4'd0;
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R2
  stage_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_cnt <= 3'd5);
  // R2
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_cnt <= 4'd6);
  // R2
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(mode_q) && $stable(state_q));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(count_o) && $stable(desc0_o) && $stable(desc1_o)
                 && $stable(desc2_o) && $stable(desc3_o) && $stable(state_o)));
  // R4
  upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> state_o[63:32] == 32'd0);
  // R4
  persist_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && state_q[1]) |-> state_o[31:0] == state_q[31:0]);
  // R5
  matrix_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && mode_q == 4'd0) |-> desc3_o == desc0_o);
  // R11
  unsupported_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (mode_q inside {4'd2, 4'd7, 4'd8, 4'd9, 4'd10})) |->
      (count_o == 7'd0 && desc0_o == 32'd0 && desc1_o == 32'd0
       && desc2_o == 32'd0 && desc3_o == 32'd0));
endmodule

bind vshape_config vshape_config_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .desc0_o(desc0_o), .desc1_o(desc1_o), .desc2_o(desc2_o),
  .desc3_o(desc3_o), .count_o(count_o), .state_o(state_o),
  .mode_q(mode_q), .state_q(state_q), .stage_cnt(stage_cnt)
);

// File: tb/vshape_config_bench.sv
`timescale 1ns/100ps
module vshape_config_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  x_i = '0, y_i = '0, z_i = '0;
  logic [3:0]  mode_i = '0;
  logic [63:0] state_i = '0;
  logic        busy_o, done_o;
  logic [31:0] desc0_o, desc1_o, desc2_o, desc3_o;
  logic [6:0]  count_o;
  logic [63:0] state_o;

  vshape_config u_vshape_config (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .x_i(x_i), .y_i(y_i),
    .z_i(z_i), .mode_i(mode_i), .state_i(state_i), .busy_o(busy_o),
    .done_o(done_o), .desc0_o(desc0_o), .desc1_o(desc1_o), .desc2_o(desc2_o),
    .desc3_o(desc3_o), .count_o(count_o), .state_o(state_o)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [31:0] d0, d1, d2, d3;
    logic [6:0]  cnt;
    logic [63:0] st;
    int          lat;
    int          startc;
    string       tag;
  } exp_t;

  exp_t exq[$];
  exp_t last_e;
  int checks = 0, fails = 0, pushes = 0, dones = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // field write with bit 0 as the word's most significant bit
  function automatic logic [31:0] put(input logic [31:0] w, input int first,
                                      input int last, input int val);
    for (int b = first; b <= last; b++) w[31-b] = val[last-b];
    return w;
  endfunction

  function automatic exp_t model(input int x, input int y, input int z,
                                 input int m, input logic [63:0] st);
    exp_t e;
    int n, acc, sz, it;
    logic [31:0] t;
    n = 0;
    while (n < 5 && ((x >> n) & 1) == 1) n++;
    e.d0 = 0; e.d1 = 0; e.d2 = 0; e.d3 = 0; e.cnt = 0;
    t = put(put(32'd0, 0, 5, x), 12, 17, z);
    case (m)
      0: begin
        e.tag = "R5";
        t = put(put(t, 6, 11, y), 28, 29, 3);
        e.d0 = t; e.d3 = t;
        e.d1 = put(put(t, 18, 20, 1), 28, 29, 1);
        e.d2 = put(t, 18, 20, 1);
        e.cnt = 7'(((x+1)*(y+1)*(z+1)) % 128);
      end
      1: begin
        e.tag = "R6";
        t = put(t, 30, 31, 1);
        e.d0 = t; e.d1 = put(t, 28, 29, 1); e.d2 = put(t, 28, 29, 2);
        e.cnt = 7'(((x+1)*n) % 128);
      end
      4, 12: begin
        e.tag = "R7";
        t = put(t, 6, 11, 3);
        if (m == 12) t = put(put(t, 30, 31, 3), 18, 20, 3);
        else t = put(put(put(t, 30, 31, 1), 18, 20, 1), 21, 23, 1);
        e.d1 = t; e.d0 = put(t, 28, 29, 1);
        e.d2 = put(put(t, 28, 29, 2), 12, 17, 0);
        e.cnt = 7'(((x+1)*n) % 128);
      end
      3, 11: begin
        e.tag = "R8";
        t = put(t, 6, 11, 2);
        if (m == 11) t = put(put(put(t, 30, 31, 3), 18, 20, 3), 21, 23, 5);
        else t = put(put(t, 30, 31, 1), 18, 20, 4);
        e.d0 = t; e.d1 = put(t, 28, 29, 1); e.d2 = put(t, 12, 17, 0);
        acc = 0; sz = 1; it = (x+1)/2;
        for (int s = 0; s < n; s++) begin acc += (it-1)*sz; sz *= 2; it /= 2; end
        e.cnt = 7'(acc % 128);
      end
      5, 13: begin
        e.tag = "R9";
        t = put(put(t, 6, 11, 4), 30, 31, 1);
        if (m == 5) t = put(t, 21, 23, 1);
        e.d0 = t; e.d1 = put(t, 28, 29, 2); e.d2 = put(t, 28, 29, 3);
        acc = 0; it = (x+1)/2;
        for (int s = 0; s < n; s++) begin acc += it; it /= 2; end
        e.cnt = 7'(acc % 128);
      end
      6, 14, 15: begin
        e.tag = "R10";
        t = put(put(t, 6, 11, 5), 30, 31, (m == 15) ? 1 : 3);
        if (m == 14) t = put(t, 18, 20, 1);
        e.d0 = t;
        e.cnt = 7'(x+1);
      end
      default: e.tag = "R11";
    endcase
    e.st = st;
    e.st[63:32] = '0;
    if (!st[1]) begin e.st[31:17] = '0; e.st[1:0] = '0; end
    e.lat = n + 2;
    e.startc = 0;
    return e;
  endfunction

  // monitor: pops one expectation per done pulse
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      dones++;
      if (exq.size() == 0) begin
        check(0, "R2", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exq.pop_front();
        check(desc0_o == e.d0, e.tag, "desc0", desc0_o, e.d0);
        check(desc1_o == e.d1, e.tag, "desc1", desc1_o, e.d1);
        check(desc2_o == e.d2, e.tag, "desc2", desc2_o, e.d2);
        check(desc3_o == e.d3, e.tag, "desc3", desc3_o, e.d3);
        check(count_o == e.cnt, e.tag, "count", count_o, e.cnt);
        check(state_o == e.st, "R4", "state", state_o, e.st);
        check(cyc - e.startc == e.lat, "R2", "latency",
              64'(cyc - e.startc), 64'(e.lat));
      end
    end
  end

  task automatic issue(input int x, input int y, input int z, input int m,
                       input logic [63:0] st);
    exp_t e;
    e = model(x, y, z, m, st);
    @(negedge clk);
    x_i = 5'(x); y_i = 5'(y); z_i = 5'(z); mode_i = 4'(m); state_i = st;
    start_i = 1'b1;
    e.startc = cyc;
    exq.push_back(e);
    pushes++;
    last_e = e;
    @(negedge clk);
    start_i = 1'b0;
    x_i = ~x_i; y_i = ~y_i; mode_i = 4'd2; state_i = ~st;
  endtask

  task automatic finish_cmd();
    while (!done_o) @(negedge clk);
    @(negedge clk);
    check(done_o == 1'b0, "R2", "done one cycle", done_o, 0);
    repeat (3) @(negedge clk);
    check(count_o == last_e.cnt, "R3", "count held", count_o, last_e.cnt);
    check(desc0_o == last_e.d0, "R3", "desc0 held", desc0_o, last_e.d0);
  endtask

  task automatic run(input int x, input int y, input int z, input int m,
                     input logic [63:0] st);
    issue(x, y, z, m, st);
    finish_cmd();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(done_o == 0 && busy_o == 0, "R1", "ctrl in reset", {done_o, busy_o}, 0);
    check(count_o == 0 && desc0_o == 0 && desc3_o == 0 && state_o == 0,
          "R1", "data in reset", count_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(count_o == 0 && desc1_o == 0 && desc2_o == 0 && done_o == 0,
          "R1", "after release", count_o, 0);

    run(1, 2, 3, 0, 64'hFFFF_FFFF_FFFF_FFFC);   // R5, persist clear (R4)
    run(7, 7, 7, 0, 64'h1234_5678_9ABC_DEF3);   // R5 wrap, persist set (R4)
    run(7, 0, 4, 1, 64'h0);                      // R6 n=3
    run(31, 0, 9, 1, 64'hFFFF_FFFF_FFFF_FFFE);  // R6 n=5 wrap
    run(0, 0, 0, 1, 64'h3);                      // R6 n=0, shortest latency
    run(15, 0, 5, 4, 64'h0);                     // R7 forward
    run(3, 0, 2, 12, 64'h0);                     // R7 inverse
    run(7, 0, 3, 3, 64'h0);                      // R8 forward
    run(31, 0, 1, 11, 64'hFFFF);                 // R8 inverse, five stages
    run(15, 0, 6, 5, 64'h0);                     // R9 forward
    run(7, 0, 2, 13, 64'h0);                     // R9 inverse
    run(12, 0, 7, 6, 64'h0);                     // R10
    run(9, 0, 3, 14, 64'h0);                     // R10
    run(20, 0, 31, 15, 64'h0);                   // R10
    run(3, 4, 5, 2, 64'hFFFF_FFFF_FFFF_FFFF);   // R11
    run(31, 1, 1, 7, 64'h0);                     // R11 with full stage run
    run(0, 1, 1, 10, 64'h0);                     // R11

    // R2: start while busy is ignored
    issue(31, 0, 2, 1, 64'h0);
    @(negedge clk);
    check(busy_o == 1'b1, "R2", "busy during stages", busy_o, 1);
    x_i = 5'd3; mode_i = 4'd0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    finish_cmd();
    repeat (12) @(negedge clk);
    check(dones == pushes, "R2", "no extra done", 64'(dones), 64'(pushes));
    check(exq.size() == 0, "R2", "all results seen", 64'(exq.size()), 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule